// File: doc/BRIEF.md
# Four-Channel Output Compare Timer

This block is a 16-bit up-counter with four compare channels. Each channel compares the counter against its own compare value. On a match, the channel drives its output pin low, drives it high, toggles it, or leaves it unchanged. The counter advances on one of two sources. The first is a tick from an internal prescaler that divides the system clock by 1, 2, 4, 8 or 32. The second is a rising edge on an external clock input, synchronised into the system clock domain first.

Software reaches the block through a small register port with a registered write strobe and a combinational read. Through it software can:
- start and stop counting;
- read and overwrite the counter;
- set the four compare values;
- set, per channel, the output enable, the match action and the initial pin level.

Channel A can set the period: the counter clears after matching it, and counting can also halt on that match. Compare C can be rerouted to act on pin A, and compare D on pin B. Match and overflow events set sticky flags, and any flag whose enable is set raises the interrupt line. A forced-cutoff input silences every pin at once.

Register map (4-bit address, 16-bit data):

| Address | Register | Contents |
|---|---|---|
| 0 | Control | bit 0 run; bits 3:1 source (0..4 divide by 1, 2, 4, 8, 32; 5 external edges; 6 and 7 no count); bit 4 clear on A; bit 5 halt on A; bit 6 route C to pin A; bit 7 route D to pin B |
| 1 | Counter | read or write |
| 2 | Flags | bits 3:0 match on A..D, bit 4 wrap; write 1 to clear |
| 3 | Interrupt enables | same bit layout as the flags |
| 4..7 | Compare A..D | compare values |
| 8 | Channel configuration | one nibble per channel, channel k at bits 4k+3:4k; in each nibble: bit 0 enable, bits 2:1 action (00 none, 01 low, 10 high, 11 toggle), bit 3 initial level |

Top module: `ocmp_timer`

## Requirements
- R1: With source 0..4, the counter advances once every 1, 2, 4, 8 or 32 clocks. The prescaler restarts whenever counting is stopped, so after m counting clocks the count has risen by floor(m / divisor).
- R2: With source 5, each rising edge on `ext_clk` advances the counter by exactly one. A rising edge is counted only if it is held for at least two clocks.
- R3: With clear-on-A off, the counter wraps from FFFFh to 0000h. That tick sets the wrap flag (bit 4).
- R4: With clear-on-A on and compare A holding n, a tick taken while the counter equals n returns it to 0. The counter therefore steps through 0..n with a period of n + 1 ticks.
- R5: While the run bit is 0, the counter and all pin levels keep their values.
- R6: With halt-on-A set, the tick that matches compare A clears the run bit. That match's clear and pin actions still apply.
- R7: On a tick where the counter equals a channel's compare value, the channel's pin level is updated by its action: 00 keep, 01 low, 10 high, 11 invert.
- R8: Writing the channel configuration while stopped loads each channel's initial level into its pin. A configuration write while running leaves the pin levels alone.
- R9: A pin whose enable bit is 0 has `pin_oe` low and `pin_out` low. An enabled pin drives its level, with `pin_oe` high.
- R10: With route C set, a C match acts on pin A with C's action, and pin C is not driven. The same holds for D and pin B under route D. If both partners match on the same tick, the rerouted channel's action is applied last and wins.
- R11: Flags stay set until software writes 1 to them. `irq` is high exactly when a flag and its enable are both 1.
- R12: While `cutoff` is high, every `pin_out` and `pin_oe` is low. When `cutoff` falls, the pins show their held levels again.
- R13: A software counter write takes priority over a tick in the same clock, and that tick is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| ext_clk | input | 1 | External count source, asynchronous |
| cutoff | input | 1 | Forced-cutoff request |
| pin_out | output | 4 | Pin levels A..D |
| pin_oe | output | 4 | Pin drive enables A..D |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can land in the same clock. In the first pair, compares A and C are given the same value with C rerouted to pin A and the two channels set to opposite actions. Pin A must then show C's level after the shared tick, while a run without routing shows A's own action. In the second pair, the counter is written while counting from the undivided clock, and counting stops one clock later. The value read back must be the written value plus one, which shows that the tick in the write cycle was dropped.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;

   localparam int unsigned OCMP_NCH = 4;

   localparam logic [3:0] ADDR_CTRL  = 4'd0;
   localparam logic [3:0] ADDR_CNT   = 4'd1;
   localparam logic [3:0] ADDR_FLAGS = 4'd2;
   localparam logic [3:0] ADDR_IEN   = 4'd3;
   localparam logic [3:0] ADDR_CMP0  = 4'd4;
   localparam logic [3:0] ADDR_CHCFG = 4'd8;

   typedef enum logic [1:0] {
      ACT_NONE   = 2'b00,
      ACT_LOW    = 2'b01,
      ACT_HIGH   = 2'b10,
      ACT_TOGGLE = 2'b11
   } ocmp_act_e;

   typedef struct packed {
      logic      init;
      ocmp_act_e act;
      logic      en;
   } ocmp_chcfg_t;

   function automatic logic ocmp_apply(input logic lvl, input ocmp_act_e a);
      logic r;
      unique case (a)
         ACT_LOW:    r = 1'b0;
         ACT_HIGH:   r = 1'b1;
         ACT_TOGGLE: r = ~lvl;
         default:    r = lvl;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/ocmp_tickgen.sv
module ocmp_tickgen #(
   parameter int PRE_W  = 5,
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic [2:0] src,
   input  logic       ext_clk,
   output logic       tick
);

   logic [PRE_W-1:0]  pre;
   logic [PRE_W-1:0]  mask;
   logic [SYNC_N:0]   chain;
   logic              rise;

   // prescaler restarts from zero whenever counting is stopped
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pre <= '0;
      else        pre <= run ? pre + 1'b1 : '0;
   end

   // synchroniser stages plus one stage for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[SYNC_N-1:0], ext_clk};
   end

   assign rise = chain[SYNC_N-1] & ~chain[SYNC_N];

   always_comb begin
      unique case (src)
         3'd1:    mask = PRE_W'(1);
         3'd2:    mask = PRE_W'(3);
         3'd3:    mask = PRE_W'(7);
         3'd4:    mask = PRE_W'(31);
         default: mask = '0;
      endcase
   end

   always_comb begin
      if (!run)              tick = 1'b0;
      else if (src <= 3'd4)  tick = ((pre & mask) == mask);
      else if (src == 3'd5)  tick = rise;
      else                   tick = 1'b0;
   end

endmodule

// File: rtl/ocmp_counter.sv
module ocmp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_on_a,
   input  logic             match_a,
   input  logic             sw_we,
   input  logic [CNT_W-1:0] sw_val,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic period_end;

   assign period_end = clr_on_a & match_a;
   assign wrap       = tick & (cnt == CNT_MAX) & ~period_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (sw_we)      cnt <= sw_val;
      else if (tick) begin
         if (period_end)   cnt <= '0;
         else              cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel
   import ocmp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      load,
   input  logic      init,
   input  logic      fire_p,
   input  ocmp_act_e act_p,
   input  logic      fire_s,
   input  ocmp_act_e act_s,
   output logic      level
);

   logic nxt;

   // the secondary (rerouted) channel is applied last and wins
   always_comb begin
      nxt = level;
      if (fire_p) nxt = ocmp_apply(nxt, act_p);
      if (fire_s) nxt = ocmp_apply(nxt, act_s);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     level <= 1'b0;
      else if (load)  level <= init;
      else            level <= nxt;
   end

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
   import ocmp_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 16,
   parameter int PRE_W  = 5,
   parameter int SYNC_N = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [3:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ext_clk,
   input  logic              cutoff,
   output logic [3:0]        pin_out,
   output logic [3:0]        pin_oe,
   output logic              irq
);

   localparam int NFLG = OCMP_NCH + 1;

   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("CNT_W must lie between 2 and DATA_W");
   end
   if (DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must hold the channel configuration word");
   end
   if (PRE_W < 5) begin : g_bad_pre_w
      $error("PRE_W must cover a divide by 32");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   logic              run, clr_a, stop_a, rt_c, rt_d;
   logic [2:0]        src;
   logic [1:0]        rt;
   logic [CNT_W-1:0]  cmp_q [OCMP_NCH];
   logic [CNT_W-1:0]  cmp_a_q;
   ocmp_chcfg_t       cfg_q [OCMP_NCH];
   logic [NFLG-1:0]   flags_q, ien_q, flag_set, flag_clr;
   logic              ctrl_we, cnt_we, flag_we, ien_we, cfg_we, load_init;
   logic              raw_tick, tick, wrap;
   logic [CNT_W-1:0]  cnt;
   logic [OCMP_NCH-1:0] match, level, own_off;

   assign ctrl_we   = bus_we && (bus_addr == ADDR_CTRL);
   assign cnt_we    = bus_we && (bus_addr == ADDR_CNT);
   assign flag_we   = bus_we && (bus_addr == ADDR_FLAGS);
   assign ien_we    = bus_we && (bus_addr == ADDR_IEN);
   assign cfg_we    = bus_we && (bus_addr == ADDR_CHCFG);
   assign load_init = cfg_we && !run;
   assign rt        = {rt_d, rt_c};
   assign cmp_a_q   = cmp_q[0];

   ocmp_tickgen #(.PRE_W(PRE_W), .SYNC_N(SYNC_N)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .src     (src),
      .ext_clk (ext_clk),
      .tick    (raw_tick)
   );

   // a software counter write swallows the tick of the same clock
   assign tick = raw_tick & ~cnt_we;

   ocmp_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .clr_on_a (clr_a),
      .match_a  (match[0]),
      .sw_we    (cnt_we),
      .sw_val   (bus_wdata[CNT_W-1:0]),
      .cnt      (cnt),
      .wrap     (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run    <= 1'b0;
         src    <= 3'd0;
         clr_a  <= 1'b0;
         stop_a <= 1'b0;
         rt_c   <= 1'b0;
         rt_d   <= 1'b0;
      end else if (ctrl_we) begin
         run    <= bus_wdata[0];
         src    <= bus_wdata[3:1];
         clr_a  <= bus_wdata[4];
         stop_a <= bus_wdata[5];
         rt_c   <= bus_wdata[6];
         rt_d   <= bus_wdata[7];
      end else if (stop_a && match[0]) begin
         run    <= 1'b0;
      end
   end

   assign flag_set = {wrap, match};
   assign flag_clr = flag_we ? bus_wdata[NFLG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         ien_q   <= '0;
      end else begin
         flags_q <= (flags_q & ~flag_clr) | flag_set;
         if (ien_we) ien_q <= bus_wdata[NFLG-1:0];
      end
   end

   assign irq = |(flags_q & ien_q);

   for (genvar k = 0; k < OCMP_NCH; k++) begin : g_ch
      logic      cmp_we, fire_p, fire_s;
      ocmp_act_e act_s;

      assign cmp_we   = bus_we && (bus_addr == 4'(ADDR_CMP0 + k));
      assign match[k] = tick && (cnt == cmp_q[k]);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cmp_q[k] <= '0;
            cfg_q[k] <= '0;
         end else begin
            if (cmp_we) cmp_q[k] <= bus_wdata[CNT_W-1:0];
            if (cfg_we) cfg_q[k] <= ocmp_chcfg_t'(bus_wdata[4*k +: 4]);
         end
      end

      if (k < 2) begin : g_host
         assign fire_p     = match[k];
         assign fire_s     = match[k+2] & rt[k];
         assign act_s      = cfg_q[k+2].act;
         assign own_off[k] = 1'b0;
      end else begin : g_guest
         assign fire_p     = match[k] & ~rt[k-2];
         assign fire_s     = 1'b0;
         assign act_s      = ACT_NONE;
         assign own_off[k] = rt[k-2];
      end

      ocmp_channel u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .load   (load_init),
         .init   (bus_wdata[4*k+3]),
         .fire_p (fire_p),
         .act_p  (cfg_q[k].act),
         .fire_s (fire_s),
         .act_s  (act_s),
         .level  (level[k])
      );

      assign pin_oe[k]  = cfg_q[k].en & ~own_off[k] & ~cutoff;
      assign pin_out[k] = pin_oe[k] & level[k];
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         ADDR_CTRL:  bus_rdata[7:0]      = {rt_d, rt_c, stop_a, clr_a, src, run};
         ADDR_CNT:   bus_rdata[CNT_W-1:0] = cnt;
         ADDR_FLAGS: bus_rdata[NFLG-1:0] = flags_q;
         ADDR_IEN:   bus_rdata[NFLG-1:0] = ien_q;
         4'd4, 4'd5, 4'd6, 4'd7:
                     bus_rdata[CNT_W-1:0] = cmp_q[bus_addr[1:0]];
         ADDR_CHCFG: begin
            for (int k = 0; k < OCMP_NCH; k++) bus_rdata[4*k +: 4] = cfg_q[k];
         end
         default:    bus_rdata = '0;
      endcase
   end

endmodule

// File: rtl/ocmp_timer_chk.sv
module ocmp_timer_chk #(
   parameter int CNT_W = 16,
   parameter int NFLG  = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cutoff,
   input logic [3:0]       pin_out,
   input logic [3:0]       pin_oe,
   input logic             run,
   input logic             tick,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] cmp_a,
   input logic             clr_a,
   input logic             stop_a,
   input logic             ctrl_we,
   input logic             cnt_we,
   input logic [NFLG-1:0]  flags,
   input logic [NFLG-1:0]  flag_clr
);

   // R12
   cutoff_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cutoff |-> (pin_out == 4'b0 && pin_oe == 4'b0));

   // R5
   stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_we) |=> $stable(cnt));

   // R4
   period_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && clr_a && cnt == cmp_a) |=> (cnt == '0));

   // R3
   count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !(clr_a && cnt == cmp_a)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

   // R6
   halt_on_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && stop_a && cnt == cmp_a && !ctrl_we) |=> !run);

   // R11
   flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags & ($past(flags) & ~$past(flag_clr))) == ($past(flags) & ~$past(flag_clr))));

endmodule

bind ocmp_timer ocmp_timer_chk #(.CNT_W(CNT_W), .NFLG(NFLG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cutoff   (cutoff),
   .pin_out  (pin_out),
   .pin_oe   (pin_oe),
   .run      (run),
   .tick     (tick),
   .cnt      (cnt),
   .cmp_a    (cmp_a_q),
   .clr_a    (clr_a),
   .stop_a   (stop_a),
   .ctrl_we  (ctrl_we),
   .cnt_we   (cnt_we),
   .flags    (flags_q),
   .flag_clr (flag_clr)
);

// File: tb/ocmp_timer_tb.sv
module ocmp_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = 4'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic        ext_clk = 1'b0;
   logic        cutoff = 1'b0;
   logic [3:0]  pin_out, pin_oe;
   logic        irq;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   ocmp_timer u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .ext_clk   (ext_clk),
      .cutoff    (cutoff),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [15:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   // m clocks of counting: the start write opens, the stop write closes
   task automatic run_edges(input logic [15:0] ctrl, input int m);
      wr(4'd0, ctrl | 16'h0001);
      repeat (m - 1) @(negedge clk);
      wr(4'd0, ctrl & 16'hFFFE);
   endtask

   function automatic logic act_fn(input logic l, input int a);
      case (a)
         1:       return 1'b0;
         2:       return 1'b1;
         3:       return ~l;
         default: return l;
      endcase
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      #400000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [15:0] v;
      logic        exp_l;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      for (int a = 0; a <= 8; a++) begin
         rd(4'(a), v);
         chk("R11 reset register", v, 0);
      end
      chk("R9 reset pin_oe", pin_oe, 0);
      chk("R11 reset irq", irq, 0);

      for (int a = 4; a <= 7; a++) wr(4'(a), 16'hFFFF);

      // R1: prescaler sweep over 100 counting clocks
      for (int s = 0; s <= 4; s++) begin
         int sh;
         sh = (s == 4) ? 5 : s;
         wr(4'd1, 16'h0000);
         run_edges(16'(s << 1), 100);
         rd(4'd1, v);
         chk($sformatf("R1 divide select %0d", s), v, 100 >> sh);
      end

      // R2: external rising edges
      wr(4'd1, 16'h0000);
      wr(4'd0, 16'h000B);
      for (int p = 0; p < 7; p++) begin
         ext_clk = 1'b1;
         repeat (3) @(negedge clk);
         ext_clk = 1'b0;
         repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      wr(4'd0, 16'h000A);
      rd(4'd1, v);
      chk("R2 external edge count", v, 7);

      // R3: wrap and overflow flag, R11 flags and irq
      wr(4'd2, 16'h001F);
      wr(4'd3, 16'h0010);
      wr(4'd1, 16'hFFFD);
      run_edges(16'h0000, 5);
      rd(4'd1, v);
      chk("R3 wrapped count", v, 2);
      rd(4'd2, v);
      chk("R3 wrap flag", v[4], 1);
      #1;
      chk("R11 irq from enabled wrap flag", irq, 1);
      wr(4'd2, 16'h0010);
      rd(4'd2, v);
      chk("R11 wrap flag cleared", v[4], 0);
      chk("R11 match flags stay set", v[3:0], 4'hF);
      chk("R11 irq low with match flags disabled", irq, 0);

      // R4: period n+1 sweep
      for (int n = 0; n <= 7; n++) begin
         wr(4'd4, 16'(n));
         wr(4'd1, 16'h0000);
         run_edges(16'h0010, 17);
         rd(4'd1, v);
         chk($sformatf("R4 period with compare %0d", n), v, 17 % (n + 1));
      end

      // R7, R8, R5: every action with both initial levels on pin A
      wr(4'd4, 16'd3);
      for (int a = 0; a <= 3; a++) begin
         for (int i = 0; i <= 1; i++) begin
            wr(4'd8, 16'((i << 3) | (a << 1) | 1));
            #1;
            chk($sformatf("R8 initial level a%0d i%0d", a, i), pin_out[0], i);
            wr(4'd1, 16'h0000);
            run_edges(16'h0010, 6);
            exp_l = act_fn(1'(i), a);
            #1;
            chk($sformatf("R7 first match a%0d i%0d", a, i), pin_out[0], exp_l);
            repeat (5) @(negedge clk);
            #1;
            chk($sformatf("R5 level held while stopped a%0d", a), pin_out[0], exp_l);
            run_edges(16'h0010, 2);
            exp_l = act_fn(exp_l, a);
            #1;
            chk($sformatf("R7 second match a%0d i%0d", a, i), pin_out[0], exp_l);
         end
      end

      // R8: configuration write while running leaves levels alone
      wr(4'd8, 16'h0001);
      wr(4'd1, 16'h0000);
      wr(4'd0, 16'h0009);
      wr(4'd8, 16'h0009);
      wr(4'd0, 16'h0008);
      #1;
      chk("R8 init ignored while running", pin_out[0], 0);

      // R10: routed collision, C wins on pin A; D toggles pin B
      wr(4'd4, 16'd3);
      wr(4'd5, 16'hFFFF);
      wr(4'd6, 16'd3);
      wr(4'd7, 16'd2);
      wr(4'd8, 16'h7513);
      wr(4'd1, 16'h0000);
      run_edges(16'h00D0, 4);
      #1;
      chk("R10 routed pins", pin_out, 4'h3);
      chk("R10 rerouted own pins released", pin_oe, 4'h3);

      // same settings without routing
      wr(4'd8, 16'h7513);
      wr(4'd1, 16'h0000);
      run_edges(16'h0010, 4);
      #1;
      chk("R7 unrouted pins", pin_out, 4'hC);
      chk("R9 all enabled pins driven", pin_oe, 4'hF);

      // R12: cutoff
      cutoff = 1'b1;
      #1;
      chk("R12 cutoff pin_out", pin_out, 0);
      chk("R12 cutoff pin_oe", pin_oe, 0);
      @(negedge clk);
      cutoff = 1'b0;
      #1;
      chk("R12 levels back after cutoff", pin_out, 4'hC);

      // R9: disabled pins
      wr(4'd8, 16'h8888);
      #1;
      chk("R9 disabled pin_oe", pin_oe, 0);
      chk("R9 disabled pin_out", pin_out, 0);
      wr(4'd8, 16'h9999);
      #1;
      chk("R9 enabled pins show initial level", pin_out, 4'hF);

      // R6: halt on A
      wr(4'd4, 16'd4);
      wr(4'd1, 16'h0000);
      wr(4'd2, 16'h001F);
      wr(4'd0, 16'h0031);
      repeat (20) @(negedge clk);
      rd(4'd0, v);
      chk("R6 run bit cleared on match", v, 16'h0030);
      rd(4'd1, v);
      chk("R6 counter cleared and held", v, 0);
      rd(4'd2, v);
      chk("R6 match A flag", v[0], 1);

      // R13: counter write beats the tick of the same clock
      wr(4'd4, 16'hFFFF);
      wr(4'd1, 16'h0000);
      wr(4'd0, 16'h0001);
      repeat (2) @(negedge clk);
      wr(4'd1, 16'h0100);
      wr(4'd0, 16'h0000);
      rd(4'd1, v);
      chk("R13 written count plus one tick", v, 16'h0101);

      summary();
      $finish;
   end

endmodule